// File: doc/BRIEF.md
# Configuration Write Guard with Init Handshake

This block stands in front of the configuration registers of a real-time clock. It watches a small register bus and decides which writes may reach the guarded registers. All writes are refused until software writes a two-byte key to a dedicated key address, in order. While the guard is open, software can raise an init request in a control register. The block then freezes the calendar counters and, after a short delay, reports that init mode is active. Loading the time, date and prescaler registers is allowed only while init mode is active.

When software drops the request, the block reports at once that init mode has ended. The freeze is held for a fixed number of clock cycles after that, and the synchronized flag rises in the same cycle that the freeze is released. Software polls this flag before it reads the calendar. The block drives a single write-enable for the guarded registers, which take their address and data directly from the shared bus. It also drives the freeze line and the status flags. The counters themselves are outside the block. Everything runs on one clock, the slow clock of the real-time clock.

Top module: `rtc_cfg_guard`

## Requirements
- R1: After reset the guard is locked, freeze is low, and init-active and synchronized are both low. A read of the control address returns 0.
- R2: The guard opens (`unlocked` high after the write edge) only when 0xCA and then 0x53 are written to the key address (9). The full data word must equal the key byte. Writes to other addresses between the two key bytes do not break the sequence.
- R3: A key-address write in the middle of the sequence that is not 0x53 returns the guard to the fully locked state. 0x53 written on its own, or right after such a wrong byte, does not open it.
- R4: Any write to the key address while the guard is open locks it again in that cycle. A value of 0xCA also counts as the first key byte, so a following 0x53 opens the guard again.
- R5: The key address always reads back 0, including during a write to it and while the guard is open.
- R6: While the guard is locked, writes to the control address (3) and to every guarded address have no effect. `guard_we` stays low, and freeze and init-active do not change.
- R7: While the guard is open, `guard_we` is high in the same cycle as a write to any address other than 3 and 9. For the calendar addresses 0, 1 and 4 it is high only while init-active is high.
- R8: Writing 1 to control bit 7 raises freeze right after that write edge. Init-active rises two cycles later. The control register reads back the request in bit 7, init-active in bit 6 and synchronized in bit 5, with all other bits 0.
- R9: Writing 0 to control bit 7 clears the request and init-active at that write edge. Freeze stays high for 4 more cycles. Synchronized rises in the same cycle that freeze falls.
- R10: Synchronized is cleared when a new init request is raised, and by an accepted control write with bit 5 at 0. An accepted control write with bit 5 at 1 leaves it unchanged.
- R11: An init request written during the exit delay cancels the exit. Freeze stays high, synchronized stays low, and init-active rises two cycles after the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Register address for the write or read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| guard_we | output | 1 | Write enable for the guarded registers |
| freeze | output | 1 | Holds the calendar counters |
| init_active | output | 1 | Init mode entered; calendar loads are allowed |
| synced | output | 1 | Counters released and running again |
| unlocked | output | 1 | Key sequence accepted; the guard is open |

## Verification
The results fall into three timing groups.

- **Same cycle as the write:** `guard_we` and `bus_rdata` are combinational and are due in the cycle of the write or read.
- **Just after the write edge:** `unlocked`, `freeze` and the clearing of init-active are registered. They are due immediately after that write's edge.
- **Counted from the write edge:** init-active is due two edges after the request write. Release of the freeze and the rise of synchronized are due four edges after the clearing write.

The driver records the cycle number of each write edge. It queues each expectation against that cycle plus the delay given in the requirement. The monitor samples every output shortly after each rising edge and compares each queued item against the sample from its own cycle. Every check therefore lands on an exact cycle and never on a window.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

   // key sequencer states
   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lock_st_e;

   // control register bit positions software depends on
   localparam int REQ_BIT = 7;
   localparam int ACT_BIT = 6;
   localparam int SYN_BIT = 5;

endpackage

// File: rtl/rtc_key_lock.sv
module rtc_key_lock
   import rtc_guard_pkg::*;
#(
   parameter int          DATA_W        = 32,
   parameter int          KEY_W         = 8,
   parameter logic [7:0]  KEY_FIRST     = 8'hCA,
   parameter logic [7:0]  KEY_SECOND    = 8'h53,
   parameter bit          KEY_FULL_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              unlocked
);

   lock_st_e   st_q, st_d;
   logic       hit_first, hit_second;
   logic       upper_ok;

   // pick the key compare variant
   generate
      if (KEY_FULL_WORD && (DATA_W > KEY_W)) begin : g_full
         assign upper_ok = (key_data[DATA_W-1:KEY_W] == '0);
      end else begin : g_low
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign hit_first  = upper_ok && (key_data[KEY_W-1:0] == KEY_FIRST[KEY_W-1:0]);
   assign hit_second = upper_ok && (key_data[KEY_W-1:0] == KEY_SECOND[KEY_W-1:0]);

   always_comb begin
      st_d = st_q;
      if (key_wr) begin
         unique case (st_q)
            LK_SHUT: st_d = hit_first  ? LK_HALF : LK_SHUT;
            LK_HALF: st_d = hit_second ? LK_OPEN : LK_SHUT;
            LK_OPEN: st_d = hit_first  ? LK_HALF : LK_SHUT;
            default: st_d = LK_SHUT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LK_SHUT;
      else        st_q <= st_d;
   end

   assign unlocked = (st_q == LK_OPEN);

   // R2
   open_needs_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && hit_second));

   // R4
   relock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && key_wr) |=> !unlocked);

   // R3
   bad_mid_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LK_HALF && key_wr && !hit_second) |=> (!unlocked && !$stable(st_q) || st_q == LK_SHUT || st_q == LK_HALF));

endmodule

// File: rtl/rtc_init_seq.sv
module rtc_init_seq #(
   parameter int ENTRY_DLY = 2,
   parameter int EXIT_DLY  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic req_val,
   input  logic syn_keep,
   output logic init_req,
   output logic init_active,
   output logic freeze,
   output logic synced
);

   localparam int ENT_W = (ENTRY_DLY < 2) ? 1 : $clog2(ENTRY_DLY);
   localparam int EXT_W = (EXIT_DLY  < 2) ? 1 : $clog2(EXIT_DLY);
   localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(ENTRY_DLY - 1);
   localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXIT_DLY - 1);

   logic             req_q, act_q, exit_q, syn_q;
   logic [ENT_W-1:0] ent_q;
   logic [EXT_W-1:0] ext_q;
   logic             req_nx, req_rise, req_fall, exit_done;

   assign req_nx    = ctl_wr ? req_val : req_q;
   assign req_rise  = req_nx && !req_q;
   assign req_fall  = req_q && !req_nx;
   assign exit_done = exit_q && !req_nx && (ext_q == EXT_LAST);

   // entry side: request held ENTRY_DLY edges before acknowledging
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         act_q <= 1'b0;
         ent_q <= '0;
      end else begin
         req_q <= req_nx;
         if (!req_nx) begin
            act_q <= 1'b0;
            ent_q <= '0;
         end else if (req_q && !act_q) begin
            if (ent_q == ENT_LAST) act_q <= 1'b1;
            else                   ent_q <= ent_q + 1'b1;
         end
      end
   end

   // exit side: freeze lingers EXIT_DLY edges after the request drops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exit_q <= 1'b0;
         ext_q  <= '0;
      end else if (req_fall) begin
         exit_q <= 1'b1;
         ext_q  <= '0;
      end else if (req_nx) begin
         exit_q <= 1'b0;
         ext_q  <= '0;
      end else if (exit_q) begin
         if (ext_q == EXT_LAST) exit_q <= 1'b0;
         else                   ext_q  <= ext_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   syn_q <= 1'b0;
      else if (req_rise)            syn_q <= 1'b0;
      else if (exit_done)           syn_q <= 1'b1;
      else if (ctl_wr && !syn_keep) syn_q <= 1'b0;
   end

   assign init_req    = req_q;
   assign init_active = act_q;
   assign freeze      = req_q | exit_q;
   assign synced      = syn_q;

   // R8
   act_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_active |-> (init_req && freeze));

   // R8
   act_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_active) |-> $past(init_req));

   // R9
   drop_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !req_val) |=> !init_active);

   // R9
   sync_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> $fell(freeze));

   // R11
   exit_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_q && ctl_wr && req_val) |=> (freeze && !synced));

endmodule

// File: rtl/rtc_guard_decode.sv
module rtc_guard_decode #(
   parameter int          ADDR_W    = 4,
   parameter int          KEY_ADDR  = 9,
   parameter int          CTRL_ADDR = 3,
   parameter int unsigned CAL_MASK  = 32'h0000_0013
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              unlocked,
   input  logic              init_active,
   output logic              key_wr,
   output logic              ctl_wr,
   output logic              guard_we
);

   localparam int                NADDR  = 1 << ADDR_W;
   localparam logic [31:0]       CMASK  = CAL_MASK;
   localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic [NADDR-1:0] cal_vec;
   logic             is_key, is_ctl, is_cal;

   generate
      for (genvar a = 0; a < NADDR; a++) begin : g_cal
         if (CMASK[a]) begin : g_on
            assign cal_vec[a] = (bus_addr == ADDR_W'(a));
         end else begin : g_off
            assign cal_vec[a] = 1'b0;
         end
      end
   endgenerate

   assign is_key = (bus_addr == KEY_A);
   assign is_ctl = (bus_addr == CTRL_A);
   assign is_cal = |cal_vec;

   assign key_wr   = bus_wr && is_key;
   assign ctl_wr   = bus_wr && is_ctl && unlocked;
   assign guard_we = bus_wr && unlocked && !is_key && !is_ctl && (!is_cal || init_active);

endmodule

// File: rtl/rtc_cfg_guard.sv
module rtc_cfg_guard
   import rtc_guard_pkg::*;
#(
   parameter int          ADDR_W        = 4,
   parameter int          DATA_W        = 32,
   parameter int          KEY_W         = 8,
   parameter logic [7:0]  KEY_FIRST     = 8'hCA,
   parameter logic [7:0]  KEY_SECOND    = 8'h53,
   parameter bit          KEY_FULL_WORD = 1'b1,
   parameter int          KEY_ADDR      = 9,
   parameter int          CTRL_ADDR     = 3,
   parameter int unsigned CAL_MASK      = 32'h0000_0013,
   parameter int          ENTRY_DLY     = 2,
   parameter int          EXIT_DLY      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              guard_we,
   output logic              freeze,
   output logic              init_active,
   output logic              synced,
   output logic              unlocked
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);

   // elaboration-time parameter checks
   generate
      if (KEY_W < 1 || KEY_W > 8 || KEY_W > DATA_W) begin : g_bad_key
         $error("key width out of range");
      end
      if (DATA_W <= REQ_BIT) begin : g_bad_data
         $error("data width too small for control bits");
      end
      if (ADDR_W < 2 || ADDR_W > 5) begin : g_bad_addr
         $error("address width out of range");
      end
      if (KEY_ADDR == CTRL_ADDR || KEY_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("key and control addresses clash or do not fit");
      end
      if (((CAL_MASK >> KEY_ADDR) & 1) != 0 || ((CAL_MASK >> CTRL_ADDR) & 1) != 0) begin : g_bad_mask
         $error("calendar mask covers key or control address");
      end
      if (ENTRY_DLY < 1 || EXIT_DLY < 1) begin : g_bad_dly
         $error("delays must be at least one cycle");
      end
   endgenerate

   logic key_wr, ctl_wr, init_req;

   rtc_guard_decode #(
      .ADDR_W    (ADDR_W),
      .KEY_ADDR  (KEY_ADDR),
      .CTRL_ADDR (CTRL_ADDR),
      .CAL_MASK  (CAL_MASK)
   ) u_dec (
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .unlocked    (unlocked),
      .init_active (init_active),
      .key_wr      (key_wr),
      .ctl_wr      (ctl_wr),
      .guard_we    (guard_we)
   );

   rtc_key_lock #(
      .DATA_W        (DATA_W),
      .KEY_W         (KEY_W),
      .KEY_FIRST     (KEY_FIRST),
      .KEY_SECOND    (KEY_SECOND),
      .KEY_FULL_WORD (KEY_FULL_WORD)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (bus_wdata),
      .unlocked (unlocked)
   );

   rtc_init_seq #(
      .ENTRY_DLY (ENTRY_DLY),
      .EXIT_DLY  (EXIT_DLY)
   ) u_init (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .req_val     (bus_wdata[REQ_BIT]),
      .syn_keep    (bus_wdata[SYN_BIT]),
      .init_req    (init_req),
      .init_active (init_active),
      .freeze      (freeze),
      .synced      (synced)
   );

   // read mux: key address falls through to zero
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_A) begin
         bus_rdata[REQ_BIT] = init_req;
         bus_rdata[ACT_BIT] = init_active;
         bus_rdata[SYN_BIT] = synced;
      end
   end

   // R6
   guard_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      guard_we |-> unlocked);

   // R6
   locked_freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !freeze) |=> !init_active);

   // R5
   key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == KEY_A) |-> (bus_rdata == '0));

endmodule

// File: tb/rtc_cfg_guard_tb.sv
module rtc_cfg_guard_tb;

   localparam int CLK_PERIOD = 10;
   localparam int KEY_A  = 9;
   localparam int CTRL_A = 3;
   localparam int S_RD = 0, S_GWE = 1, S_FRZ = 2, S_ACT = 3, S_SYN = 4, S_UNL = 5;
   localparam int HDEPTH = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        guard_we, freeze, init_active, synced, unlocked;

   rtc_cfg_guard u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .guard_we    (guard_we),
      .freeze      (freeze),
      .init_active (init_active),
      .synced      (synced),
      .unlocked    (unlocked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      int          sel;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] hist [0:5][0:HDEPTH-1];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   function automatic string sel_name(int s);
      case (s)
         S_RD:    return "rdata";
         S_GWE:   return "guard_we";
         S_FRZ:   return "freeze";
         S_ACT:   return "init_active";
         S_SYN:   return "synced";
         default: return "unlocked";
      endcase
   endfunction

   // monitor: sample after each edge, then retire due expectations
   always @(posedge clk) begin
      cyc++;
      #2;
      hist[S_RD][cyc % HDEPTH]  = bus_rdata;
      hist[S_GWE][cyc % HDEPTH] = {31'd0, guard_we};
      hist[S_FRZ][cyc % HDEPTH] = {31'd0, freeze};
      hist[S_ACT][cyc % HDEPTH] = {31'd0, init_active};
      hist[S_SYN][cyc % HDEPTH] = {31'd0, synced};
      hist[S_UNL][cyc % HDEPTH] = {31'd0, unlocked};
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].cyc <= cyc) begin
            logic [31:0] got;
            got = hist[sb_q[i].sel][sb_q[i].cyc % HDEPTH];
            checks++;
            if (got !== sb_q[i].val) begin
               errors++;
               $display("FAIL %s: %s at cycle %0d got 0x%0h expected 0x%0h",
                        sb_q[i].tag, sel_name(sb_q[i].sel), sb_q[i].cyc, got, sb_q[i].val);
            end
            sb_q.delete(i);
         end
      end
   end

   task automatic expect_at(input int c, input int sel, input logic [31:0] v, input string tag);
      exp_t e;
      e.cyc = c; e.sel = sel; e.val = v; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // one write; returns the cycle number of its write edge
   task automatic wr(input int a, input logic [31:0] d, output int edge_cyc);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      edge_cyc = cyc;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp_v, input string tag);
      @(negedge clk);
      bus_addr = 4'(a);
      expect_at(cyc + 1, S_RD, exp_v, tag);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete got hung expected done");
         finish_run();
      end
   end

   initial begin
      int e, e2, e3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_at(cyc + 1, S_UNL, 0, "R1");
      expect_at(cyc + 1, S_FRZ, 0, "R1");
      expect_at(cyc + 1, S_ACT, 0, "R1");
      expect_at(cyc + 1, S_SYN, 0, "R1");
      rd(CTRL_A, 32'h0, "R1");

      // R6 locked: control and guarded writes ignored
      wr(CTRL_A, 32'h80, e);
      expect_at(e, S_FRZ, 0, "R6");
      expect_at(e + 2, S_ACT, 0, "R6");
      wr(5, 32'h1234, e);
      expect_at(e, S_GWE, 0, "R6");
      rd(CTRL_A, 32'h0, "R6");

      // R3 partial and broken sequences
      wr(KEY_A, 32'h53, e);
      expect_at(e, S_UNL, 0, "R3");
      wr(KEY_A, 32'hCA, e);
      wr(KEY_A, 32'h12, e);
      expect_at(e, S_UNL, 0, "R3");
      wr(KEY_A, 32'h53, e);
      expect_at(e, S_UNL, 0, "R3");

      // R2 correct sequence with unrelated write between bytes
      wr(KEY_A, 32'hCA, e);
      wr(5, 32'h0, e);
      expect_at(e, S_GWE, 0, "R6");
      wr(KEY_A, 32'h53, e);
      expect_at(e, S_UNL, 1, "R2");
      expect_at(e, S_RD, 0, "R5");
      rd(KEY_A, 32'h0, "R5");

      // R7 decode while open, not in init
      wr(5, 32'hA5, e);
      expect_at(e, S_GWE, 1, "R7");
      wr(2, 32'hA5, e);
      expect_at(e, S_GWE, 1, "R7");
      wr(0, 32'h11, e);
      expect_at(e, S_GWE, 0, "R7");

      // R8 init entry
      expect_at(cyc + 1, S_FRZ, 0, "R8");
      wr(CTRL_A, 32'h80, e);
      expect_at(e, S_FRZ, 1, "R8");
      expect_at(e, S_ACT, 0, "R8");
      expect_at(e + 1, S_ACT, 0, "R8");
      expect_at(e + 2, S_ACT, 1, "R8");
      rd(CTRL_A, 32'hC0, "R8");
      wr(4, 32'h3FF, e);
      expect_at(e, S_GWE, 1, "R7");
      wr(1, 32'h2101, e);
      expect_at(e, S_GWE, 1, "R7");

      // R9 init exit
      wr(CTRL_A, 32'h00, e);
      expect_at(e, S_ACT, 0, "R9");
      expect_at(e, S_FRZ, 1, "R9");
      expect_at(e + 3, S_FRZ, 1, "R9");
      expect_at(e + 3, S_SYN, 0, "R9");
      expect_at(e + 4, S_FRZ, 0, "R9");
      expect_at(e + 4, S_SYN, 1, "R9");
      idle(5);
      rd(CTRL_A, 32'h20, "R8");

      // R10 synced clear rules
      wr(CTRL_A, 32'h20, e);
      expect_at(e, S_SYN, 1, "R10");
      wr(CTRL_A, 32'h00, e);
      expect_at(e, S_SYN, 0, "R10");

      // R11 re-request during exit delay
      wr(CTRL_A, 32'h80, e);
      idle(3);
      wr(CTRL_A, 32'h00, e2);
      wr(CTRL_A, 32'h80, e3);
      expect_at(e2 + 4, S_FRZ, 1, "R11");
      expect_at(e2 + 5, S_FRZ, 1, "R11");
      expect_at(e2 + 4, S_SYN, 0, "R11");
      expect_at(e2 + 5, S_SYN, 0, "R11");
      expect_at(e3 + 2, S_ACT, 1, "R11");
      idle(3);
      wr(CTRL_A, 32'h00, e);
      expect_at(e + 4, S_SYN, 1, "R9");
      idle(5);
      wr(CTRL_A, 32'h80, e);
      expect_at(e, S_SYN, 0, "R10");
      idle(2);
      wr(CTRL_A, 32'h00, e);
      idle(5);

      // R4 relock and restart
      wr(KEY_A, 32'hFF, e);
      expect_at(e, S_UNL, 0, "R4");
      wr(5, 32'h7, e);
      expect_at(e, S_GWE, 0, "R6");
      wr(KEY_A, 32'hCA, e);
      wr(KEY_A, 32'h53, e);
      expect_at(e, S_UNL, 1, "R2");
      wr(KEY_A, 32'hCA, e);
      expect_at(e, S_UNL, 0, "R4");
      wr(KEY_A, 32'h53, e);
      expect_at(e, S_UNL, 1, "R4");
      rd(KEY_A, 32'h0, "R5");
      wr(KEY_A, 32'hFF, e);
      expect_at(e, S_UNL, 0, "R4");

      idle(4);
      wait (sb_q.size() == 0);
      done = 1'b1;
      finish_run();
   end

endmodule